// File: doc/BRIEF.md
# Five-Channel Edge Capture Unit

The block timestamps external events. One free-running 16-bit counter serves as a shared timebase. Five capture channels each watch one asynchronous input pin. When a channel's pin makes a transition that its edge-select bits allow, the channel copies the counter into its own 16-bit capture register. It then sets a sticky per-channel event flag.

The flags, the counter-run bit and a counter-wrap flag sit together in one control byte. A single interrupt line is raised while any flag whose interrupt enable is set is asserted. Software reads and writes the unit through a byte-wide register port: write strobe, 5-bit address, write data and a combinational read-data bus. Flags are cleared only by writing 0 to their bit, so servicing the interrupt does not lose events.

Register layout. `addr[4:3]` selects a region and `addr[2:0]` an index:
- Region 0, index 0: control byte. Bit 7 is run, bit 6 is the wrap flag, bit 5 reads 0, bits 4..0 are the channel flags.
- Region 0, index 1: bit 0 is the wrap interrupt enable.
- Region 0, indices 2 and 3: counter low and high byte, read-only.
- Region 1: per-channel mode byte. Bit 0 enables rising-edge capture, bit 1 enables falling-edge capture, bit 2 is the channel interrupt enable.
- Region 2: capture low byte.
- Region 3: capture high byte.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset the control byte, the wrap interrupt enable, the counter, every mode byte and every capture register read 0, and `irq` is 0.
- R2: The counter (read at addresses 2 and 3) advances by one on every clock while the run bit (control bit 7) is 1, and holds its value while the run bit is 0.
- R3: When the counter steps from 0xFFFF to 0x0000, the wrap flag (control bit 6) is set.
- R4: With mode bit 0 set, a low-to-high change on a channel's pin loads the counter into that channel's capture register (low byte at 0x10+n, high byte at 0x18+n) and sets control bit n.
- R5: With mode bit 1 set, a high-to-low change on the pin captures and sets the flag, in the same way as R4.
- R6: With both mode bits 0 and 1 set, either direction of change captures.
- R7: With mode bits 0 and 1 both clear, pin changes have no effect: the flag and the capture register keep their values.
- R8: A pin change sampled at clock edge k sets the flag at edge k+2 and not earlier. The captured value is the counter value held just before edge k+2, so two pins changing together capture equal values, and pins changing three cycles apart capture values that differ by 3 while the counter runs.
- R9: Flags are sticky. Writing 0 to a flag bit (or to bit 6) clears it, and writing 1 leaves it unchanged. A capture in the same cycle as a clearing write leaves the flag set.
- R10: A new capture overwrites the capture register even while the channel's flag is still set.
- R11: `irq` is 1 exactly when some channel flag is set with its mode bit 2 set, or the wrap flag is set with the wrap interrupt enable set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cap_in | input | 5 | Asynchronous capture pins, one per channel |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, combinational from `addr` |
| irq | output | 1 | Shared interrupt request |

## Verification
A vector table drives each edge-select setting through both a rising and a falling pin change. Each row checks whether the flag and the capture register moved, which separates rising-only, falling-only, either-edge and disabled channels. The counter is frozen at a different known value for every row, so a stale or wrong capture value shows up. Directed tests pin down the two-cycle capture latency, relative timestamps with the counter running, the write-zero-to-clear rule, and a capture that collides with a clearing write. They also cover overwrite while the flag is set, the interrupt masking per source, and a full counter wrap.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 5;
  localparam int IDX_W  = 3;
  localparam int RUN_BIT = 7;
  localparam int OVF_BIT = 6;

  typedef struct packed {
    logic ien;
    logic fall_en;
    logic rise_en;
  } mode_t;

  typedef enum logic [1:0] {
    RG_GLOBAL = 2'd0,
    RG_MODE   = 2'd1,
    RG_CAPLO  = 2'd2,
    RG_CAPHI  = 2'd3
  } region_e;

  localparam logic [IDX_W-1:0] G_CTRL   = 3'd0;
  localparam logic [IDX_W-1:0] G_OVFIEN = 3'd1;
  localparam logic [IDX_W-1:0] G_CNTLO  = 3'd2;
  localparam logic [IDX_W-1:0] G_CNTHI  = 3'd3;
endpackage

// File: rtl/ecu_rst_sync.sv
module ecu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_sn  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_sn  <= stage_q;
    end
  end
endmodule

// File: rtl/ecu_timebase.sv
module ecu_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (run) cnt_d = cnt_q + CNT_W'(1);
    wrap = run && (cnt_q == CNT_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ecu_channel.sv
module ecu_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic             rise_en,
  input  logic             fall_en,
  input  logic [CNT_W-1:0] cnt_val,
  output logic             hit,
  output logic [CNT_W-1:0] cap_val
);
  logic             meta_q, sync_q, prev_q;
  logic             rose, fell;
  logic [CNT_W-1:0] cap_q, cap_d;

  always_comb begin
    rose  = sync_q & ~prev_q;
    fell  = ~sync_q & prev_q;
    hit   = (rise_en & rose) | (fall_en & fell);
    cap_d = hit ? cnt_val : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      prev_q <= sync_q;
      cap_q  <= cap_d;
    end
  end

  assign cap_val = cap_q;
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecu_pkg::*;
#(
  parameter int NCH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    cap_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic                          rst_sn;
  logic                          run_q, run_d;
  logic                          ovf_q, ovf_d;
  logic                          ovf_ien_q, ovf_ien_d;
  logic [NCH-1:0]                flag_q, flag_d;
  mode_t                         mode_q [NCH];
  mode_t                         mode_d [NCH];
  logic [NCH-1:0]                hit;
  logic [NCH-1:0]                edge_en;
  logic [NCH-1:0]                ien_vec;
  logic [NCH-1:0][CNT_W-1:0]     cap_q;
  logic [CNT_W-1:0]              cnt;
  logic                          wrap;
  region_e                       region;
  logic [IDX_W-1:0]              idx;
  logic                          wr_ctrl, wr_ovfien, wr_mode;
  logic [DATA_W-1:0]             ctrl_rd;

  ecu_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_sn(rst_sn)
  );

  ecu_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk  (clk),
    .rst_n(rst_sn),
    .run  (run_q),
    .cnt  (cnt),
    .wrap (wrap)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ecu_channel #(.CNT_W(CNT_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_sn),
      .pin    (cap_in[g]),
      .rise_en(mode_q[g].rise_en),
      .fall_en(mode_q[g].fall_en),
      .cnt_val(cnt),
      .hit    (hit[g]),
      .cap_val(cap_q[g])
    );
  end

  // address decode
  always_comb begin
    region    = region_e'(addr[ADDR_W-1:IDX_W]);
    idx       = addr[IDX_W-1:0];
    wr_ctrl   = wr_en && (region == RG_GLOBAL) && (idx == G_CTRL);
    wr_ovfien = wr_en && (region == RG_GLOBAL) && (idx == G_OVFIEN);
    wr_mode   = wr_en && (region == RG_MODE);
  end

  // next state
  always_comb begin
    run_d     = wr_ctrl ? wdata[RUN_BIT] : run_q;
    ovf_ien_d = wr_ovfien ? wdata[0] : ovf_ien_q;
    ovf_d     = wrap | (ovf_q & ~(wr_ctrl & ~wdata[OVF_BIT]));
    for (int i = 0; i < NCH; i++) begin
      flag_d[i]  = hit[i] | (flag_q[i] & ~(wr_ctrl & ~wdata[i]));
      mode_d[i]  = (wr_mode && (idx == IDX_W'(i))) ? mode_t'(wdata[2:0]) : mode_q[i];
      edge_en[i] = mode_q[i].rise_en | mode_q[i].fall_en;
      ien_vec[i] = mode_q[i].ien;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      run_q     <= 1'b0;
      ovf_q     <= 1'b0;
      ovf_ien_q <= 1'b0;
      flag_q    <= '0;
      for (int i = 0; i < NCH; i++) mode_q[i] <= '0;
    end else begin
      run_q     <= run_d;
      ovf_q     <= ovf_d;
      ovf_ien_q <= ovf_ien_d;
      flag_q    <= flag_d;
      for (int i = 0; i < NCH; i++) mode_q[i] <= mode_d[i];
    end
  end

  // interrupt
  always_comb irq = (|(flag_q & ien_vec)) | (ovf_q & ovf_ien_q);

  // read mux
  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[RUN_BIT] = run_q;
    ctrl_rd[OVF_BIT] = ovf_q;
    ctrl_rd[NCH-1:0] = flag_q;
    rdata            = '0;
    unique case (region)
      RG_GLOBAL: begin
        if (idx == G_CTRL)   rdata = ctrl_rd;
        if (idx == G_OVFIEN) rdata = {{(DATA_W-1){1'b0}}, ovf_ien_q};
        if (idx == G_CNTLO)  rdata = cnt[DATA_W-1:0];
        if (idx == G_CNTHI)  rdata = cnt[CNT_W-1:DATA_W];
      end
      RG_MODE: begin
        for (int i = 0; i < NCH; i++)
          if (idx == IDX_W'(i)) rdata = {{(DATA_W-3){1'b0}}, mode_q[i]};
      end
      RG_CAPLO: begin
        for (int i = 0; i < NCH; i++)
          if (idx == IDX_W'(i)) rdata = cap_q[i][DATA_W-1:0];
      end
      RG_CAPHI: begin
        for (int i = 0; i < NCH; i++)
          if (idx == IDX_W'(i)) rdata = cap_q[i][CNT_W-1:DATA_W];
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/ecu_checker.sv
module ecu_checker #(
  parameter int NCH   = 5,
  parameter int CNT_W = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      run,
  input logic [CNT_W-1:0]          cnt,
  input logic                      ovf,
  input logic [NCH-1:0]            flags,
  input logic                      irq,
  input logic                      wr_ctrl,
  input logic [7:0]                wdata,
  input logic [NCH-1:0][CNT_W-1:0] cap,
  input logic [NCH-1:0]            edge_en
);
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> $stable(cnt)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) |-> cnt == CNT_W'($past(cnt) + CNT_W'(1))); // R2
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && ($past(cnt) == {CNT_W{1'b1}})) |-> ovf); // R3
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((|flags) || ovf)); // R11

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_CAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap[i]) |-> flags[i]); // R4
    AST_CAP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(edge_en[i]) |-> ($stable(cap[i]) && !$rose(flags[i]))); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[i]) |-> ($past(wr_ctrl) && !$past(wdata[i]))); // R9
  end
endmodule

bind edge_capture_unit ecu_checker #(.NCH(NCH), .CNT_W(ecu_pkg::CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sn),
  .run    (run_q),
  .cnt    (cnt),
  .ovf    (ovf_q),
  .flags  (flag_q),
  .irq    (irq),
  .wr_ctrl(wr_ctrl),
  .wdata  (wdata),
  .cap    (cap_q),
  .edge_en(edge_en)
);

// File: tb/edge_capture_unit_test.sv
`timescale 1ns/1ps
module edge_capture_unit_test;
  logic       clk;
  logic       rst_n;
  logic [4:0] cap_in;
  logic       wr_en;
  logic [4:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq;

  int total = 0;
  int bad   = 0;
  int model_cnt = 0;

  edge_capture_unit uut (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {mode[1:0], pin start, pin end, capture expected}
  localparam logic [4:0] VEC [8] = '{
    {2'd1, 1'b0, 1'b1, 1'b1},
    {2'd1, 1'b1, 1'b0, 1'b0},
    {2'd2, 1'b1, 1'b0, 1'b1},
    {2'd2, 1'b0, 1'b1, 1'b0},
    {2'd3, 1'b0, 1'b1, 1'b1},
    {2'd3, 1'b1, 1'b0, 1'b1},
    {2'd0, 1'b0, 1'b1, 1'b0},
    {2'd0, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    addr = a;
    #0.5 d = rdata;
  endtask

  task automatic rd16(input logic [4:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd(lo, l);
    rd(lo + 5'd8, h);
    v = {h, l};
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] l, h;
    rd(5'h02, l);
    rd(5'h03, h);
    v = {h, l};
  endtask

  // counter advances exactly n times (n >= 1); flags preserved
  task automatic run_for(input int n);
    wr(5'h00, 8'hDF);
    repeat (n - 1) @(posedge clk);
    wr(5'h00, 8'h5F);
    model_cnt = (model_cnt + n) % 65536;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w, old_cap, a2, a4;
    rst_n = 1'b0; cap_in = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1 reset state
    rd(5'h00, b);  check("R1 ctrl", b, 0);
    rd(5'h01, b);  check("R1 wrap ien", b, 0);
    rd_cnt(w);     check("R1 counter", w, 0);
    rd(5'h0B, b);  check("R1 mode ch3", b, 0);
    rd16(5'h14, w); check("R1 capture ch4", w, 0);
    check("R1 irq", irq, 0);

    // table walk: R4 R5 R6 R7
    for (int v = 0; v < 8; v++) begin
      int ch;
      string tag;
      logic [1:0] m;
      ch = v % 5;
      m = VEC[v][4:3];
      tag = (m == 2'd1) ? "R4" : (m == 2'd2) ? "R5" : (m == 2'd3) ? "R6" : "R7";
      wr(5'h08 + 5'(ch), 8'h00);
      @(negedge clk) cap_in[ch] = VEC[v][2];
      repeat (4) @(posedge clk);
      run_for(3 + v);
      wr(5'h00, 8'h00);
      wr(5'h08 + 5'(ch), {6'b0, m});
      rd16(5'h10 + 5'(ch), old_cap);
      @(negedge clk) cap_in[ch] = VEC[v][1];
      repeat (4) @(posedge clk);
      #1;
      rd(5'h00, b);
      check({tag, " flag"}, b[ch], VEC[v][0]);
      rd16(5'h10 + 5'(ch), w);
      check({tag, " capture"}, w, VEC[v][0] ? model_cnt : old_cap);
      wr(5'h08 + 5'(ch), 8'h00);
    end

    // R2 counter run / hold
    run_for(100);
    rd_cnt(w); check("R2 counter after run", w, model_cnt);
    repeat (10) @(posedge clk);
    #1 rd_cnt(w); check("R2 counter holds", w, model_cnt);

    // R8 latency (ch1 rising)
    wr(5'h00, 8'h00);
    wr(5'h09, 8'h01);
    @(negedge clk) cap_in[1] = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) cap_in[1] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1 rd(5'h00, b); check("R8 flag not before k+2", b[1], 0);
    @(posedge clk);
    #1 rd(5'h00, b); check("R8 flag at k+2", b[1], 1);
    rd16(5'h11, w);  check("R8 captured frozen counter", w, model_cnt);

    // R8 relative timestamps with running counter (ch2, ch3, ch4 rising)
    @(negedge clk) begin cap_in[2] = 1'b0; cap_in[3] = 1'b0; cap_in[4] = 1'b0; end
    wr(5'h0A, 8'h01); wr(5'h0B, 8'h01); wr(5'h0C, 8'h01);
    repeat (4) @(posedge clk);
    wr(5'h00, 8'hDF);
    repeat (5) @(posedge clk);
    @(negedge clk) begin cap_in[2] = 1'b1; cap_in[3] = 1'b1; end
    repeat (3) @(posedge clk);
    @(negedge clk) cap_in[4] = 1'b1;
    repeat (6) @(posedge clk);
    wr(5'h00, 8'h5F);
    rd16(5'h12, a2); rd16(5'h13, w);
    check("R8 simultaneous pins equal", w, a2);
    rd16(5'h14, a4);
    check("R8 three-cycle spacing", 16'(a4 - a2), 3);
    rd_cnt(w); model_cnt = w;

    // R9 write 1 keeps, write 0 clears
    wr(5'h00, 8'h5F);
    rd(5'h00, b); check("R9 write one keeps flag", b[1], 1);
    wr(5'h00, 8'h5D);
    rd(5'h00, b); check("R9 write zero clears flag", b[1], 0);
    rd(5'h00, b); check("R9 other flags untouched", b[2], 1);

    // R9 capture wins over same-cycle clear
    @(negedge clk) cap_in[1] = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) cap_in[1] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    wr(5'h00, 8'h5D);
    #1 rd(5'h00, b); check("R9 capture beats clear", b[1], 1);

    // R10 overwrite while flag set
    run_for(5);
    @(negedge clk) cap_in[1] = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) cap_in[1] = 1'b1;
    repeat (4) @(posedge clk);
    #1 rd16(5'h11, w); check("R10 overwrite with flag set", w, model_cnt);

    // R11 masking (ch1 flag set, ch2..4 flags set, all ien 0)
    check("R11 irq masked", irq, 0);
    wr(5'h09, 8'h05);
    #1 check("R11 irq on enabled flag", irq, 1);
    wr(5'h00, 8'h5D);
    #1 check("R11 irq drops after clear", irq, 0);

    // R3 wrap
    wr(5'h00, 8'h1F);
    rd(5'h00, b); check("R3 wrap flag clear before", b[6], 0);
    run_for(65536 - model_cnt);
    rd_cnt(w); check("R3 counter wrapped", w, 0);
    rd(5'h00, b); check("R3 wrap flag set", b[6], 1);
    check("R11 wrap masked", irq, 0);
    wr(5'h01, 8'h01);
    #1 check("R11 wrap enabled irq", irq, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule